// File: doc/BRIEF.md
# Power-on strap capture and frequency code select

This block sits between a set of shared configuration pins and the clock synthesis logic. While power-on reset is held, the shared pins act as inputs. The block samples a 4-bit frequency strap and a mode strap from them on every clock edge. The first edge with reset released freezes both values, and the pins are then turned into clock outputs.

After reset, the block picks the active 4-bit frequency code. It takes either the frozen strap code or a code that software writes into configuration register 0. Register 0 also supplies three controls: the spread-spectrum enable, the spread depth and a global tristate. The block registers each of these and presents them as flags.

The mode strap decides the role of two further pins. In desktop mode they are clock outputs. In mobile mode they are active-low stop-request inputs, which the block turns into registered stop requests. Every output is registered, so each input change appears one clock after the edge that samples it. A change of the selected frequency code is reported by a one-cycle strobe, which lets downstream logic move smoothly to the new frequency.

Top module: `strap_fsel_top`

## Requirements
- R1: At every clock edge with `rst_n` low, `pin_oe_o` and `dual_oe_o` become all zeros and `fsel_chg_o` becomes 0.
- R2: The frequency strap is the value of `strap_pins_i` at the last clock edge with `rst_n` low. Changes on `strap_pins_i` after reset is released have no effect until the next reset.
- R3: `mode_o` is the value of `mode_pin_i` at the last clock edge with `rst_n` low (1 = desktop, 0 = mobile). It stays constant until the next reset.
- R4: After an edge with `rst_n` high and register bit 0 clear, `pin_oe_o` is all ones (one bit per shared pin: four frequency straps plus the mode strap).
- R5: When register bit 3 is 1 at an edge, `fsel_o` after that edge is {bit 2, bit 6, bit 5, bit 4} of register 0, with bit 2 as the MSB.
- R6: When register bit 3 is 0 at an edge, `fsel_o` after that edge is the frozen strap code.
- R7: `fsel_chg_o` is 1 for exactly the one cycle in which `fsel_o` holds a new value. It is never 1 at reset release.
- R8: After each edge with reset released, `ss_en_o` equals register bit 1 and `ss_wide_o` equals register bit 7 (0 = ±0.25%, 1 = ±0.6%). Both are 0 after an edge in reset.
- R9: When register bit 0 is 1 at an edge, `tristate_o` is 1 and both `pin_oe_o` and `dual_oe_o` are all zeros after that edge.
- R10: In desktop mode, `dual_oe_o` is all ones (unless tristated) and `stop_req_o` is 0. In mobile mode, `dual_oe_o` is 0 and `stop_req_o[i]` is the inverse of `stop_n_i[i]` sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, sampled synchronously |
| strap_pins_i | input | 4 | Level on the frequency strap pins |
| mode_pin_i | input | 1 | Level on the mode strap pin |
| stop_n_i | input | N_DUAL | Active-low stop requests on the dual-role pins |
| cfg_reg0_i | input | 8 | Configuration register 0 |
| pin_oe_o | output | 5 | Output enable for the shared strap pins |
| dual_oe_o | output | N_DUAL | Output enable for the dual-role pins |
| stop_req_o | output | N_DUAL | Registered stop requests (mobile mode) |
| mode_o | output | 1 | Captured mode strap |
| fsel_o | output | 4 | Active frequency code |
| fsel_chg_o | output | 1 | One-cycle strobe on a new frequency code |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_wide_o | output | 1 | Spread depth select |
| tristate_o | output | 1 | All clock outputs tristated |

## Verification
On every cycle, the assertions check four things: the outputs go dark during reset, the mode strap stays frozen, the software code is assembled in its bit order, and the change strobe matches the code transitions. The spread and tristate flags and the quiet dual-role enables in mobile mode are checked on every cycle as well. Some behaviour can only be shown by the bench's scenarios. One case is that the strap value taken is the one at the final reset edge, not an earlier one. Another is that later pin movement leaves the code alone. A third is the absence of a strobe when software selects a code equal to the current one. The stop-request path across a second reset that changes the mode is also left to the scenarios.

// File: rtl/strap_fsel_pkg.sv
package strap_fsel_pkg;
    localparam int unsigned FSEL_W     = 4;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned N_SHARED   = FSEL_W + 1;
    localparam int unsigned BIT_TRI    = 0;
    localparam int unsigned BIT_SS     = 1;
    localparam int unsigned BIT_MSB    = 2;
    localparam int unsigned BIT_SRC    = 3;
    localparam int unsigned BIT_LO     = 4;
    localparam int unsigned BIT_DEPTH  = 7;

    // Software code: bit 2 on top, then bits 6..4.
    function automatic logic [FSEL_W-1:0] sw_code(input logic [REG_W-1:0] r);
        return {r[BIT_MSB], r[BIT_LO+FSEL_W-2:BIT_LO]};
    endfunction
endpackage

// File: rtl/strap_fsel_latch.sv
module strap_fsel_latch
    import strap_fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] strap_pins_i,
    input  logic              mode_pin_i,
    output logic [FSEL_W-1:0] strap_o,
    output logic              mode_o
);
    typedef struct packed {
        logic [FSEL_W-1:0] strap;
        logic              mode;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.strap = strap_pins_i;
            st_d.mode  = mode_pin_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign strap_o = st_q.strap;
    assign mode_o  = st_q.mode;
endmodule

// File: rtl/strap_fsel_mux.sv
module strap_fsel_mux
    import strap_fsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] strap_pins_i,
    input  logic [FSEL_W-1:0] strap_q_i,
    input  logic              src_sw_i,
    input  logic [FSEL_W-1:0] sw_code_i,
    output logic [FSEL_W-1:0] fsel_o,
    output logic              chg_o
);
    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic              chg;
    } mux_st_t;

    mux_st_t st_d, st_q;
    logic [FSEL_W-1:0] pick;

    always_comb begin
        pick = src_sw_i ? sw_code_i : strap_q_i;
        st_d = st_q;
        if (!rst_n) begin
            // Track the pins so the frozen strap and the code agree at release.
            st_d.fsel = strap_pins_i;
            st_d.chg  = 1'b0;
        end else begin
            st_d.fsel = pick;
            st_d.chg  = (pick != st_q.fsel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fsel_o = st_q.fsel;
    assign chg_o  = st_q.chg;
endmodule

// File: rtl/strap_fsel_pinctl.sv
module strap_fsel_pinctl
    import strap_fsel_pkg::*;
#(
    parameter int unsigned N_DUAL = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic                tri_i,
    input  logic                ss_i,
    input  logic                depth_i,
    input  logic [N_DUAL-1:0]   stop_n_i,
    output logic [N_SHARED-1:0] pin_oe_o,
    output logic [N_DUAL-1:0]   dual_oe_o,
    output logic [N_DUAL-1:0]   stop_req_o,
    output logic                ss_en_o,
    output logic                ss_wide_o,
    output logic                tristate_o
);
    typedef struct packed {
        logic [N_SHARED-1:0] oe;
        logic [N_DUAL-1:0]   dual_oe;
        logic [N_DUAL-1:0]   stop;
        logic                ss;
        logic                wide;
        logic                tri_st;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic [N_DUAL-1:0] lane_oe, lane_stop;
    logic              drive_ok;

    assign drive_ok = rst_n & ~tri_i;

    for (genvar i = 0; i < N_DUAL; i++) begin : g_lane
        assign lane_oe[i]   = drive_ok & mode_i;
        assign lane_stop[i] = rst_n & ~mode_i & ~stop_n_i[i];
    end

    always_comb begin
        st_d         = st_q;
        st_d.oe      = {N_SHARED{drive_ok}};
        st_d.dual_oe = lane_oe;
        st_d.stop    = lane_stop;
        st_d.ss      = rst_n & ss_i;
        st_d.wide    = rst_n & depth_i;
        st_d.tri_st  = rst_n & tri_i;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin_oe_o   = st_q.oe;
    assign dual_oe_o  = st_q.dual_oe;
    assign stop_req_o = st_q.stop;
    assign ss_en_o    = st_q.ss;
    assign ss_wide_o  = st_q.wide;
    assign tristate_o = st_q.tri_st;
endmodule

// File: rtl/strap_fsel_top.sv
module strap_fsel_top
    import strap_fsel_pkg::*;
#(
    parameter int unsigned N_DUAL = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FSEL_W-1:0]   strap_pins_i,
    input  logic                mode_pin_i,
    input  logic [N_DUAL-1:0]   stop_n_i,
    input  logic [REG_W-1:0]    cfg_reg0_i,
    output logic [N_SHARED-1:0] pin_oe_o,
    output logic [N_DUAL-1:0]   dual_oe_o,
    output logic [N_DUAL-1:0]   stop_req_o,
    output logic                mode_o,
    output logic [FSEL_W-1:0]   fsel_o,
    output logic                fsel_chg_o,
    output logic                ss_en_o,
    output logic                ss_wide_o,
    output logic                tristate_o
);
    logic [FSEL_W-1:0] strap_q;
    logic              mode_q;

    strap_fsel_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_pins_i (strap_pins_i),
        .mode_pin_i   (mode_pin_i),
        .strap_o      (strap_q),
        .mode_o       (mode_q)
    );

    strap_fsel_mux u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_pins_i (strap_pins_i),
        .strap_q_i    (strap_q),
        .src_sw_i     (cfg_reg0_i[BIT_SRC]),
        .sw_code_i    (sw_code(cfg_reg0_i)),
        .fsel_o       (fsel_o),
        .chg_o        (fsel_chg_o)
    );

    strap_fsel_pinctl #(.N_DUAL(N_DUAL)) u_pinctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_q),
        .tri_i      (cfg_reg0_i[BIT_TRI]),
        .ss_i       (cfg_reg0_i[BIT_SS]),
        .depth_i    (cfg_reg0_i[BIT_DEPTH]),
        .stop_n_i   (stop_n_i),
        .pin_oe_o   (pin_oe_o),
        .dual_oe_o  (dual_oe_o),
        .stop_req_o (stop_req_o),
        .ss_en_o    (ss_en_o),
        .ss_wide_o  (ss_wide_o),
        .tristate_o (tristate_o)
    );

    assign mode_o = mode_q;
endmodule

// File: rtl/strap_fsel_chk.sv
module strap_fsel_chk
    import strap_fsel_pkg::*;
#(
    parameter int unsigned N_DUAL = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [REG_W-1:0]    cfg_reg0_i,
    input logic [N_SHARED-1:0] pin_oe_o,
    input logic [N_DUAL-1:0]   dual_oe_o,
    input logic                mode_o,
    input logic [FSEL_W-1:0]   fsel_o,
    input logic                fsel_chg_o,
    input logic                ss_en_o,
    input logic                ss_wide_o,
    input logic                tristate_o
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_dark_in_reset_R1: assert property (@(posedge clk) disable iff (!past_ok)
        !$past(rst_n) |-> (pin_oe_o == '0 && dual_oe_o == '0 && !fsel_chg_o));

    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_o));

    assert_sw_code_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_reg0_i[3]))
        |-> (fsel_o == {$past(cfg_reg0_i[2]), $past(cfg_reg0_i[6]),
                        $past(cfg_reg0_i[5]), $past(cfg_reg0_i[4])}));

    assert_strobe_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fsel_chg_o == (fsel_o != $past(fsel_o))));

    assert_spread_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ss_en_o == $past(cfg_reg0_i[1]) && ss_wide_o == $past(cfg_reg0_i[7])));

    assert_tristate_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_reg0_i[0]))
        |-> (tristate_o && pin_oe_o == '0 && dual_oe_o == '0));

    assert_mobile_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> (dual_oe_o == '0));
endmodule

bind strap_fsel_top strap_fsel_chk #(.N_DUAL(N_DUAL)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_reg0_i (cfg_reg0_i),
    .pin_oe_o   (pin_oe_o),
    .dual_oe_o  (dual_oe_o),
    .mode_o     (mode_o),
    .fsel_o     (fsel_o),
    .fsel_chg_o (fsel_chg_o),
    .ss_en_o    (ss_en_o),
    .ss_wide_o  (ss_wide_o),
    .tristate_o (tristate_o)
);

// File: tb/strap_fsel_tb.sv
module strap_fsel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'b0000;
    logic       mode_pin = 1'b1;
    logic [1:0] stop_n = 2'b11;
    logic [7:0] cfg = 8'h00;

    logic [4:0] pin_oe;
    logic [1:0] dual_oe, stop_req;
    logic       mode, chg, ss_en, ss_wide, tri_st;
    logic [3:0] fsel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference state
    logic [3:0] m_strap, m_fsel;
    logic       m_mode, m_chg, m_ss, m_wide, m_tri, m_inrst, m_sw, m_moved;
    logic [4:0] m_oe;
    logic [1:0] m_dual, m_stop;

    always #4 clk = ~clk;

    strap_fsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .strap_pins_i(pins), .mode_pin_i(mode_pin),
        .stop_n_i(stop_n), .cfg_reg0_i(cfg), .pin_oe_o(pin_oe), .dual_oe_o(dual_oe),
        .stop_req_o(stop_req), .mode_o(mode), .fsel_o(fsel), .fsel_chg_o(chg),
        .ss_en_o(ss_en), .ss_wide_o(ss_wide), .tristate_o(tri_st)
    );

    always @(posedge clk) begin
        logic [3:0] want;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_strap = pins; m_mode = mode_pin; m_fsel = pins; m_chg = 0;
            m_oe = 0; m_dual = 0; m_stop = 0; m_ss = 0; m_wide = 0; m_tri = 0;
            m_inrst = 1; m_sw = 0; m_moved = 0;
        end else begin
            m_inrst = 0;
            m_sw = cfg[3];
            if (pins != m_strap) m_moved = 1;
            if (cfg[3]) begin
                want[3] = cfg[2]; want[2] = cfg[6]; want[1] = cfg[5]; want[0] = cfg[4];
            end else begin
                want = m_strap;
            end
            m_chg  = (want != m_fsel);
            m_fsel = want;
            m_tri  = cfg[0];
            m_oe   = cfg[0] ? 5'b00000 : 5'b11111;
            m_dual = (m_mode && !cfg[0]) ? 2'b11 : 2'b00;
            m_stop = m_mode ? 2'b00 : ~stop_n;
            m_ss   = cfg[1];
            m_wide = cfg[7];
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cmp(m_inrst ? "R1" : (m_tri ? "R9" : "R4"), "pin_oe", pin_oe, m_oe);
            cmp(m_inrst ? "R1" : (m_tri ? "R9" : "R10"), "dual_oe", dual_oe, m_dual);
            cmp("R10", "stop_req", stop_req, m_stop);
            cmp("R3", "mode", mode, m_mode);
            cmp(m_sw ? "R5" : (m_moved ? "R2" : "R6"), "fsel", fsel, m_fsel);
            cmp(m_inrst ? "R1" : "R7", "fsel_chg", chg, m_chg);
            cmp("R8", "ss_en", ss_en, m_ss);
            cmp("R8", "ss_wide", ss_wide, m_wide);
            cmp("R9", "tristate", tri_st, m_tri);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        // R1/R2/R3: straps sampled during reset, last reset edge wins
        pins = 4'b1011; mode_pin = 1'b1;
        wait_n(3);
        pins = 4'b0110;
        wait_n(2);
        rst_n = 1'b1;                 // R4, R6: strap code, no strobe at release
        wait_n(3);
        pins = 4'b1111; mode_pin = 1'b0; // R2, R3: ignored after reset
        wait_n(3);
        cfg = 8'h2C;                  // R5: code 1010
        wait_n(3);
        cfg = 8'h68;                  // R5: code 0110
        wait_n(2);
        cfg = 8'h60;                  // R6: back to strap 0110, no strobe (R7)
        wait_n(2);
        cfg = 8'h08;                  // R5: code 0000
        wait_n(2);
        cfg = 8'h70;                  // R6: field ignored when source is strap
        wait_n(2);
        cfg = 8'h02; wait_n(2);       // R8
        cfg = 8'h82; wait_n(2);
        cfg = 8'h80; wait_n(2);
        cfg = 8'h01; wait_n(3);       // R9
        cfg = 8'h00; wait_n(2);
        stop_n = 2'b01; wait_n(2);    // R10: desktop ignores stop pins
        // second reset in mobile mode
        rst_n = 1'b0; mode_pin = 1'b0; pins = 4'b0001; stop_n = 2'b11;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        stop_n = 2'b10; wait_n(2);    // R10
        stop_n = 2'b00; wait_n(2);
        stop_n = 2'b11; wait_n(1);
        cfg = 8'h19; wait_n(3);       // R5 + R9 together: code 0001
        cfg = 8'h3C; wait_n(3);       // R5: code 1011
        cfg = 8'h00; wait_n(3);
        finish_run();
    end
endmodule